// File: doc/BRIEF.md
# AXI4-Lite Power-Down Isolation Gate

This block sits on the link between a single AXI4-Lite manager and a single subordinate and lets the subordinate be retired safely before its supply is switched off. While no isolation is requested, every channel signal passes straight through. The path is purely combinational, so no cycle is added to any handshake.

When `iso_req` rises, the gate stops admitting new address phases from the manager. It lets every transaction that the subordinate has already accepted run to completion, and then detaches the subordinate. It signals this by raising `iso_ack`. While detached, the gate is itself the responder. Each write address plus write data pair receives an error write response. Each read address receives error read data of zero. The subordinate sees no VALID at all during this time.

Lowering `iso_req` reconnects the subordinate, but only after every response the gate itself owes has been delivered. Reconnection does not happen in the middle of a stand-in transaction.

Top module: `axil_iso_gate`

## Requirements
- R1: While not isolating, each manager-side signal is copied to the subordinate side and each subordinate-side signal to the manager side in the same cycle, with no register in the path.
- R2: Once a request is being served, a new write or read address offered by the manager is neither forwarded (subordinate-side AW/AR VALID low) nor acknowledged (manager-side AW/AR READY low).
- R3: While draining, write responses and read data from the subordinate for already accepted transactions are still forwarded to the manager.
- R4: `iso_ack` rises only after every accepted write (counted from address acceptance to response handshake) and every accepted read (counted from address acceptance to read data handshake) has completed, and it stays high while isolated.
- R5: While `iso_ack` is high, the AW, W and AR VALID outputs toward the subordinate are low.
- R6: While isolated, a write receives a write response of 2'b10 (error) once both its address and its data have been accepted, and not before.
- R7: While isolated, a read receives read data of all zeros with a read response of 2'b10 (error).
- R8: After `iso_req` falls, the gate returns to pass-through only once no stand-in write or read is pending. Until then it accepts no new address, and `iso_ack` stays high.
- R9: If a write's data was accepted by the subordinate before its address, then while draining that write's address is still forwarded, so that the write completes before isolation.
- R10: A VALID already presented to the subordinate but not yet accepted is not withdrawn by an isolation request while the manager keeps offering it.
- R11: At most MAX_OUT writes and MAX_OUT reads are outstanding. At the limit, further addresses in that direction get READY low and are not forwarded.
- R12: After reset the gate is in pass-through, with `iso_ack` low and no stand-in response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_req | input | 1 | Request to detach the subordinate |
| iso_ack | output | 1 | High while the subordinate is detached |
| s_awvalid | input | 1 | Manager write address valid |
| s_awready | output | 1 | Write address ready to manager |
| s_awaddr | input | ADDR_W | Manager write address |
| s_wvalid | input | 1 | Manager write data valid |
| s_wready | output | 1 | Write data ready to manager |
| s_wdata | input | DATA_W | Manager write data |
| s_wstrb | input | DATA_W/8 | Manager write byte strobes |
| s_bvalid | output | 1 | Write response valid to manager |
| s_bready | input | 1 | Manager write response ready |
| s_bresp | output | 2 | Write response code to manager |
| s_arvalid | input | 1 | Manager read address valid |
| s_arready | output | 1 | Read address ready to manager |
| s_araddr | input | ADDR_W | Manager read address |
| s_rvalid | output | 1 | Read data valid to manager |
| s_rready | input | 1 | Manager read data ready |
| s_rdata | output | DATA_W | Read data to manager |
| s_rresp | output | 2 | Read response code to manager |
| m_awvalid | output | 1 | Write address valid to subordinate |
| m_awready | input | 1 | Subordinate write address ready |
| m_awaddr | output | ADDR_W | Write address to subordinate |
| m_wvalid | output | 1 | Write data valid to subordinate |
| m_wready | input | 1 | Subordinate write data ready |
| m_wdata | output | DATA_W | Write data to subordinate |
| m_wstrb | output | DATA_W/8 | Write byte strobes to subordinate |
| m_bvalid | input | 1 | Subordinate write response valid |
| m_bready | output | 1 | Write response ready to subordinate |
| m_bresp | input | 2 | Subordinate write response code |
| m_arvalid | output | 1 | Read address valid to subordinate |
| m_arready | input | 1 | Subordinate read address ready |
| m_araddr | output | ADDR_W | Read address to subordinate |
| m_rvalid | input | 1 | Subordinate read data valid |
| m_rready | output | 1 | Read data ready to subordinate |
| m_rdata | input | DATA_W | Subordinate read data |
| m_rresp | input | 2 | Subordinate read response code |

## Verification
The hardest situation to reach is a write whose data beat the subordinate accepted before its address, with the isolation request arriving in between. In that state the gate must forward exactly one address while draining, even though it blocks all other new addresses. The stimulus reaches it by completing a lone W handshake in pass-through mode and then raising the request before any AW is offered. A second hard case is a release of the request while a stand-in write is half accepted. The bench reaches it by handing the gate only the address during isolation, dropping the request, and supplying the data afterwards.

// File: rtl/axil_iso_pkg.sv
package axil_iso_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ISO   = 2'd2
  } iso_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/axil_iso_cnt.sv
module axil_iso_cnt #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic zero
);
  localparam int CNT_W = $clog2(MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + CNT_W'(1);
    else if (dec && !inc) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (inc != dec)  cnt_q <= cnt_d;
  end

  assign full = (cnt_q == CNT_W'(MAX));
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/axil_iso_track.sv
module axil_iso_track #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aw_hs,
  input  logic w_hs,
  input  logic b_hs,
  input  logic ar_hs,
  input  logic r_hs,
  input  logic aw_pend,
  input  logic w_pend,
  input  logic ar_pend,
  output logic wr_full,
  output logic wr_zero,
  output logic rd_full,
  output logic rd_zero,
  output logic aw_lead,
  output logic w_lead,
  output logic w_floor,
  output logic bal_zero,
  output logic aw_stall,
  output logic w_stall,
  output logic ar_stall
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int BAL_W = CNT_W + 1;
  localparam int NDIR  = 2;

  logic [NDIR-1:0] inc_v, dec_v, full_v, zero_v;

  assign inc_v = {ar_hs, aw_hs};
  assign dec_v = {r_hs, b_hs};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    axil_iso_cnt #(.MAX(MAX_OUT)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc_v[g]),
      .dec  (dec_v[g]),
      .full (full_v[g]),
      .zero (zero_v[g])
    );
  end

  assign wr_full = full_v[0];
  assign wr_zero = zero_v[0];
  assign rd_full = full_v[1];
  assign rd_zero = zero_v[1];

  // address-minus-data balance of writes seen by the subordinate
  logic signed [BAL_W-1:0] bal_q, bal_d;
  logic                    bal_en;

  assign bal_en = aw_hs ^ w_hs;

  always_comb begin
    bal_d = bal_q;
    if (aw_hs && !w_hs)      bal_d = bal_q + BAL_W'(1);
    else if (w_hs && !aw_hs) bal_d = bal_q - BAL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bal_q <= '0;
    else if (bal_en) bal_q <= bal_d;
  end

  assign aw_lead  = (bal_q > 0);
  assign w_lead   = (bal_q < 0);
  assign bal_zero = (bal_q == '0);
  assign w_floor  = (bal_q == -BAL_W'(MAX_OUT));

  logic [2:0] stall_q, stall_d;

  assign stall_d = {ar_pend, w_pend, aw_pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= '0;
    else        stall_q <= stall_d;
  end

  assign aw_stall = stall_q[0];
  assign w_stall  = stall_q[1];
  assign ar_stall = stall_q[2];

endmodule

// File: rtl/axil_iso_ctrl.sv
module axil_iso_ctrl
  import axil_iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_req,
  input  logic       quiet,
  input  logic       stub_idle,
  output iso_state_e state
);
  iso_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS:  if (iso_req) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!iso_req)   state_d = ST_PASS;
        else if (quiet) state_d = ST_ISO;
      end
      ST_ISO:   if (!iso_req && stub_idle) state_d = ST_PASS;
      default:  state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PASS;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/axil_iso_stub.sv
module axil_iso_stub
  import axil_iso_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              iso_req,
  input  logic              awvalid,
  output logic              awready,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              idle
);
  logic aw_got_q, w_got_q, bv_q, rv_q;
  logic aw_got_d, w_got_d, bv_d, rv_d;
  logic aw_hs, w_hs, ar_hs;

  assign awready = active && !aw_got_q && !bv_q && (iso_req || w_got_q);
  assign wready  = active && !w_got_q && !bv_q && (iso_req || aw_got_q);
  assign arready = active && !rv_q && iso_req;

  assign aw_hs = awvalid && awready;
  assign w_hs  = wvalid && wready;
  assign ar_hs = arvalid && arready;

  always_comb begin
    aw_got_d = aw_got_q | aw_hs;
    w_got_d  = w_got_q | w_hs;
    bv_d     = bv_q && !bready;
    if (aw_got_d && w_got_d) begin
      bv_d     = 1'b1;
      aw_got_d = 1'b0;
      w_got_d  = 1'b0;
    end
    rv_d = ar_hs | (rv_q && !rready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      bv_q     <= 1'b0;
      rv_q     <= 1'b0;
    end else begin
      aw_got_q <= aw_got_d;
      w_got_q  <= w_got_d;
      bv_q     <= bv_d;
      rv_q     <= rv_d;
    end
  end

  assign bvalid = bv_q;
  assign bresp  = RESP_SLVERR;
  assign rvalid = rv_q;
  assign rdata  = '0;
  assign rresp  = RESP_SLVERR;
  assign idle   = !aw_got_q && !w_got_q && !bv_q && !rv_q;

endmodule

// File: rtl/axil_iso_gate.sv
module axil_iso_gate
  import axil_iso_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iso_req,
  output logic                iso_ack,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp
);
  iso_state_e state;
  logic in_pass, in_drain, in_iso;
  logic wr_full, wr_zero, rd_full, rd_zero;
  logic aw_lead, w_lead, w_floor, bal_zero;
  logic aw_stall, w_stall, ar_stall;
  logic aw_open, w_open, ar_open;
  logic quiet, stub_idle;
  logic stub_awready, stub_wready, stub_bvalid, stub_arready, stub_rvalid;
  logic [1:0] stub_bresp, stub_rresp;
  logic [DATA_W-1:0] stub_rdata;

  assign in_pass  = (state == ST_PASS);
  assign in_drain = (state == ST_DRAIN);
  assign in_iso   = (state == ST_ISO);

  // admission of each request channel toward the subordinate
  always_comb begin
    aw_open = 1'b0;
    w_open  = 1'b0;
    ar_open = 1'b0;
    if (in_pass) begin
      aw_open = aw_stall || !wr_full;
      w_open  = w_stall || !w_floor;
      ar_open = ar_stall || !rd_full;
    end else if (in_drain) begin
      aw_open = aw_stall || w_lead;
      w_open  = w_stall || aw_lead;
      ar_open = ar_stall;
    end
  end

  assign m_awvalid = s_awvalid && aw_open;
  assign m_wvalid  = s_wvalid && w_open;
  assign m_arvalid = s_arvalid && ar_open;
  assign m_bready  = s_bready && !in_iso;
  assign m_rready  = s_rready && !in_iso;

  assign m_awaddr = s_awaddr;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_araddr = s_araddr;

  assign s_awready = in_iso ? stub_awready : (m_awready && aw_open);
  assign s_wready  = in_iso ? stub_wready  : (m_wready && w_open);
  assign s_arready = in_iso ? stub_arready : (m_arready && ar_open);
  assign s_bvalid  = in_iso ? stub_bvalid  : m_bvalid;
  assign s_bresp   = in_iso ? stub_bresp   : m_bresp;
  assign s_rvalid  = in_iso ? stub_rvalid  : m_rvalid;
  assign s_rdata   = in_iso ? stub_rdata   : m_rdata;
  assign s_rresp   = in_iso ? stub_rresp   : m_rresp;

  axil_iso_track #(.MAX_OUT(MAX_OUT)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .aw_hs   (m_awvalid && m_awready),
    .w_hs    (m_wvalid && m_wready),
    .b_hs    (m_bvalid && m_bready),
    .ar_hs   (m_arvalid && m_arready),
    .r_hs    (m_rvalid && m_rready),
    .aw_pend (m_awvalid && !m_awready),
    .w_pend  (m_wvalid && !m_wready),
    .ar_pend (m_arvalid && !m_arready),
    .wr_full (wr_full),
    .wr_zero (wr_zero),
    .rd_full (rd_full),
    .rd_zero (rd_zero),
    .aw_lead (aw_lead),
    .w_lead  (w_lead),
    .w_floor (w_floor),
    .bal_zero(bal_zero),
    .aw_stall(aw_stall),
    .w_stall (w_stall),
    .ar_stall(ar_stall)
  );

  assign quiet = wr_zero && rd_zero && bal_zero && !aw_stall && !w_stall && !ar_stall;

  axil_iso_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .iso_req  (iso_req),
    .quiet    (quiet),
    .stub_idle(stub_idle),
    .state    (state)
  );

  axil_iso_stub #(.DATA_W(DATA_W)) u_stub (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_iso),
    .iso_req(iso_req),
    .awvalid(s_awvalid),
    .awready(stub_awready),
    .wvalid (s_wvalid),
    .wready (stub_wready),
    .bvalid (stub_bvalid),
    .bready (s_bready),
    .bresp  (stub_bresp),
    .arvalid(s_arvalid),
    .arready(stub_arready),
    .rvalid (stub_rvalid),
    .rready (s_rready),
    .rdata  (stub_rdata),
    .rresp  (stub_rresp),
    .idle   (stub_idle)
  );

  assign iso_ack = in_iso;

endmodule

// File: rtl/axil_iso_gate_chk.sv
module axil_iso_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iso_ack,
  input logic              s_awvalid,
  input logic              s_arvalid,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              wr_zero,
  input logic              rd_zero
);
  // R5: nothing is offered to a detached subordinate
  a_r5_no_valid_out: assert property (@(posedge clk) disable iff (!rst_n)
    iso_ack |-> !m_awvalid && !m_wvalid && !m_arvalid);

  // R4: detachment only with both outstanding counts empty
  a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_ack) |-> $past(wr_zero && rd_zero));

  // R6: stand-in write response is an error
  a_r6_bresp_err: assert property (@(posedge clk) disable iff (!rst_n)
    iso_ack && s_bvalid |-> s_bresp == 2'b10);

  // R7: stand-in read data is zero with an error code
  a_r7_rdata_err: assert property (@(posedge clk) disable iff (!rst_n)
    iso_ack && s_rvalid |-> s_rresp == 2'b10 && s_rdata == '0);

  // R10: a stalled VALID toward the subordinate stays up while the manager holds it
  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(m_awvalid && !m_awready) && s_awvalid |-> m_awvalid);

  a_r10_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(m_arvalid && !m_arready) && s_arvalid |-> m_arvalid);

  // R8: a stand-in write response is held until taken
  a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    iso_ack && s_bvalid && !s_bready |=> s_bvalid);

endmodule

bind axil_iso_gate axil_iso_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iso_ack  (iso_ack),
  .s_awvalid(s_awvalid),
  .s_arvalid(s_arvalid),
  .m_awvalid(m_awvalid),
  .m_awready(m_awready),
  .m_wvalid (m_wvalid),
  .m_arvalid(m_arvalid),
  .m_arready(m_arready),
  .s_bvalid (s_bvalid),
  .s_bready (s_bready),
  .s_bresp  (s_bresp),
  .s_rvalid (s_rvalid),
  .s_rdata  (s_rdata),
  .s_rresp  (s_rresp),
  .wr_zero  (wr_zero),
  .rd_zero  (rd_zero)
);

// File: tb/axil_iso_gate_tb.sv
`timescale 1ns/1ps
module axil_iso_gate_tb;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int MAX_OUT = 4;
  localparam int NVEC    = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic iso_req, iso_ack;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic [ADDR_W-1:0] s_awaddr, s_araddr, m_awaddr, m_araddr;
  logic [DATA_W-1:0] s_wdata, m_wdata, s_rdata, m_rdata;
  logic [DATA_W/8-1:0] s_wstrb, m_wstrb;
  logic [1:0] s_bresp, s_rresp, m_bresp, m_rresp;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  axil_iso_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .iso_req(iso_req), .iso_ack(iso_ack),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
  );

  // inputs {s_awvalid,m_awready,s_wvalid,m_wready,s_arvalid,m_arready}
  // expected {m_awvalid,s_awready,m_wvalid,s_wready,m_arvalid,s_arready}
  localparam logic [11:0] VEC [NVEC] = '{
    {6'b000000, 6'b000000},
    {6'b010101, 6'b010101},
    {6'b101010, 6'b101010},
    {6'b111111, 6'b111111},
    {6'b110000, 6'b110000},
    {6'b001100, 6'b001100},
    {6'b000011, 6'b000011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    iso_req = 0;
    s_awvalid = 0; s_wvalid = 0; s_bready = 0; s_arvalid = 0; s_rready = 0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '0;
    m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 2'b00;
    m_arready = 0; m_rvalid = 0; m_rdata = '0; m_rresp = 2'b00;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    do_reset();
    // R12: reset state
    chk("R12 ack", {31'b0, iso_ack}, 0);
    chk("R12 bvalid", {31'b0, s_bvalid}, 0);
    chk("R12 rvalid", {31'b0, s_rvalid}, 0);

    // R1: table of pass-through patterns
    for (int i = 0; i < NVEC; i++) begin
      {s_awvalid, m_awready, s_wvalid, m_wready, s_arvalid, m_arready} = VEC[i][11:6];
      s_awaddr = 32'h1000 + i; s_araddr = 32'h2000 + i; s_wdata = 32'h3000 + i;
      #1;
      chk("R1 handshake", {26'b0, m_awvalid, s_awready, m_wvalid, s_wready, m_arvalid, s_arready},
          {26'b0, VEC[i][5:0]});
      chk("R1 addr", m_awaddr ^ m_araddr ^ m_wdata, (32'h1000 + i) ^ (32'h2000 + i) ^ (32'h3000 + i));
      tick();
    end

    // R2..R8 drain, isolate, release
    do_reset();
    s_awvalid = 1; s_wvalid = 1; m_awready = 1; m_wready = 1; s_arvalid = 1; m_arready = 1;
    tick();
    idle_in(); iso_req = 1;
    tick();
    s_arvalid = 1; m_arready = 1; s_awvalid = 1; m_awready = 1;
    #1;
    chk("R2 ar fwd", {31'b0, m_arvalid}, 0);
    chk("R2 ar rdy", {31'b0, s_arready}, 0);
    chk("R2 aw blk", {30'b0, m_awvalid, s_awready}, 0);
    s_arvalid = 0; s_awvalid = 0; m_arready = 0; m_awready = 0;
    m_bvalid = 1; s_bready = 1; m_bresp = 2'b01;
    #1;
    chk("R3 b fwd", {29'b0, s_bvalid, s_bresp}, 3'b101);
    chk("R4 no ack early", {31'b0, iso_ack}, 0);
    tick();
    m_bvalid = 0; s_bready = 0;
    m_rvalid = 1; s_rready = 1; m_rdata = 32'hA5A5_0001;
    #1;
    chk("R3 r fwd", s_rdata, 32'hA5A5_0001);
    chk("R3 r rdy", {31'b0, m_rready}, 1);
    tick();
    m_rvalid = 0; s_rready = 0;
    #1 chk("R4 ack after last", {31'b0, iso_ack}, 0);
    tick();
    chk("R4 ack", {31'b0, iso_ack}, 1);
    s_awvalid = 1; s_wvalid = 1; m_awready = 1; m_wready = 1;
    #1;
    chk("R5 quiet", {29'b0, m_awvalid, m_wvalid, m_arvalid}, 0);
    chk("R6 accept", {30'b0, s_awready, s_wready}, 2'b11);
    tick();
    s_awvalid = 0; s_wvalid = 0; m_awready = 0; m_wready = 0;
    #1 chk("R6 bresp", {29'b0, s_bvalid, s_bresp}, 3'b110);
    s_bready = 1;
    tick();
    s_bready = 0;
    s_awvalid = 1;
    #1 chk("R6 no b before data", {31'b0, s_bvalid}, 0);
    tick();
    s_awvalid = 0;
    #1 chk("R6 aw only no b", {31'b0, s_bvalid}, 0);
    s_arvalid = 1;
    tick();
    s_arvalid = 0;
    #1 chk("R7 read", {s_rdata[29:0], s_rvalid, s_rresp == 2'b10}, 32'h3);
    s_rready = 1;
    tick();
    s_rready = 0;
    iso_req = 0;
    tick();
    s_awvalid = 1; s_arvalid = 1;
    #1 chk("R8 hold ack", {29'b0, iso_ack, s_awready, s_arready}, 3'b100);
    s_awvalid = 0; s_arvalid = 0;
    s_wvalid = 1;
    #1 chk("R8 data taken", {31'b0, s_wready}, 1);
    tick();
    s_wvalid = 0;
    #1 chk("R8 b pending", {30'b0, iso_ack, s_bvalid}, 2'b11);
    s_bready = 1;
    tick();
    s_bready = 0;
    #1 chk("R8 still iso", {31'b0, iso_ack}, 1);
    tick();
    s_arvalid = 1;
    #1 chk("R8 back to pass", {30'b0, iso_ack, m_arvalid}, 2'b01);
    s_arvalid = 0;

    // R9: data ahead of address, then request
    do_reset();
    s_wvalid = 1; m_wready = 1;
    tick();
    idle_in(); iso_req = 1;
    tick();
    s_awvalid = 1;
    #1 chk("R9 aw fwd", {31'b0, m_awvalid}, 1);
    m_awready = 1;
    tick();
    s_awvalid = 0; m_awready = 0;
    m_bvalid = 1; s_bready = 1;
    tick();
    m_bvalid = 0; s_bready = 0;
    #1 chk("R9 not yet", {31'b0, iso_ack}, 0);
    tick();
    chk("R9 isolated", {31'b0, iso_ack}, 1);

    // R10: stalled AR kept up across the request
    do_reset();
    s_arvalid = 1;
    tick();
    iso_req = 1;
    tick();
    #1 chk("R10 held", {31'b0, m_arvalid}, 1);
    m_arready = 1;
    tick();
    s_arvalid = 0; m_arready = 0;

    // R11: read outstanding limit
    do_reset();
    s_arvalid = 1; m_arready = 1;
    repeat (MAX_OUT) tick();
    #1 chk("R11 limit", {30'b0, s_arready, m_arvalid}, 0);
    s_arvalid = 0; m_arready = 0;
    tick();

    summary();
  end

endmodule